// File: doc/BRIEF.md
# Data-Link Message Transmitter with Completion Interrupt

This block sends one data-link message as an HDLC-style framed bit stream. A host loads the message bytes into an internal buffer, sets the message length and requests transmission. The block then sends the frame one bit per data-link slot. A slot is marked by a strobe from the surrounding line framer, so no free-running bit clock is involved. Each frame carries an opening flag, the message bytes and a 16-bit frame check sequence, and it ends with a closing flag. Zero bits are inserted so that the flag pattern cannot appear inside the frame. When the closing flag has gone out, a status bit sets and an active-low interrupt can be raised.

The host side is a simple single-cycle register port. It has a write strobe, a read strobe, an address, write data, and read data that decodes combinationally from the address. A read strobe to the control register clears the completion status. The line side behaves as a stream that always has a valid bit. The slot strobe acts as the ready signal from the framer, and every cycle in which the strobe is high consumes exactly one bit. The block cannot push back on the framer. When no frame is in progress, each slot carries a 1.

Top module: `lapd_tx`

## Requirements
- R1: After reset, the control register (address 0x00) reads 0x00, `irq_n` is 1 and `line_bit` is 1.
- R2: A frame consists of the opening flag 0x7E, the message bytes in buffer order, the FCS and the closing flag 0x7E. Every byte goes out least significant bit first. `line_bit` takes the next frame bit at the clock edge where `slot` is sampled high, and holds that bit between slots.
- R3: After five consecutive 1 bits in the message data or the FCS, a single 0 bit is inserted before the next bit. This includes the case where the next bit is the first bit of the closing flag. Flag bits are never stuffed, and they restart the count of ones.
- R4: The FCS uses the bit-reversed CCITT CRC-16 (generator 0x8408, shifted right, message bits fed least significant bit first). The register is preset to 0xFFFF, updated over the message data bits only, and sent complemented with its low bit first.
- R5: The length register at address 0x01 sets how many buffer bytes are sent. A written value above DEPTH saturates to DEPTH. A length of 0 sends flag, FCS and flag only.
- R6: Writing 1 to control bit 3 (start) while the block is idle makes bit 3 read 1 until the next slot. On that slot the first flag bit goes out, bit 3 returns to 0 and bit 2 (busy) becomes 1. Busy returns to 0 at the slot that carries the last closing-flag bit.
- R7: A write of start while busy is 1, or while a start is still pending, is ignored. After the frame ends, only idle 1s follow.
- R8: Control bit 0 (status) sets at the slot that completes the frame. A read strobe to address 0x00 clears it. If the completion and such a read fall in the same cycle, status remains set.
- R9: `irq_n` is 0 exactly when status is 1 and control bit 1 (interrupt enable, read/write) is 1.
- R10: Control bits 7:4 read 0. Buffer byte i is written and read back at address BUF_BASE+i (0x86 to 0xDD by default).
- R11: Every slot that falls outside a frame carries a 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (clears status when addr is 0x00) |
| addr | input | AW | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data for addr |
| slot | input | 1 | Data-link bit slot strobe (stream ready) |
| line_bit | output | 1 | Outgoing data-link bit |
| irq_n | output | 1 | Active-low completion interrupt |

## Verification
The bench uses the default parameters: an 88-byte buffer based at 0x86 and an 8-bit address. With these defaults, a full-length frame of 88 random bytes can be sent, and an over-range length write exercises the saturation. Random message bytes are mixed with all-ones messages that stuff heavily. Slot gaps are random, and an empty message is also sent. The expected line bits come from a reference frame builder written in the bench. The bench also hits two same-cycle corners: a completion that coincides with a status read, and a start written during a frame.

// File: rtl/lapd_tx_pkg.sv
package lapd_tx_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_OPEN, PH_DATA, PH_FCS, PH_CLOSE} phase_e;

  localparam logic [7:0]  FLAG_BYTE    = 8'h7E;
  localparam logic [15:0] CRC_GEN_REV  = 16'h8408;
  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
  localparam int          STUFF_RUN    = 5;

  function automatic logic [15:0] crc_bit_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    crc_bit_step = (c >> 1) ^ (fb ? CRC_GEN_REV : 16'h0000);
  endfunction
endpackage

// File: rtl/lapd_tx_crc.sv
module lapd_tx_crc
  import lapd_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      crc_q <= CRC_PRESET;
    else if (init_i) crc_q <= CRC_PRESET;
    else if (en_i)   crc_q <= crc_bit_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/lapd_tx_regs.sv
module lapd_tx_regs #(
  parameter int DEPTH    = 88,
  parameter int BUF_BASE = 'h86,
  parameter int AW       = 8,
  parameter int IW       = 7,
  parameter int LW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_byte,
  output logic [LW-1:0] len_o,
  output logic          start_pend_o,
  input  logic          take_i,
  input  logic          busy_i,
  input  logic          done_i,
  output logic          irq_n
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(0);
  localparam logic [AW-1:0] LEN_ADDR  = AW'(1);

  logic [7:0]    mem [DEPTH];
  logic          pend_q, en_q, stat_q;
  logic [LW-1:0] len_q;
  logic          in_buf, hit_ctrl, hit_len;
  logic [IW-1:0] buf_idx;

  assign in_buf   = (int'(addr) >= BUF_BASE) && (int'(addr) < BUF_BASE + DEPTH);
  assign buf_idx  = IW'(addr - AW'(BUF_BASE));
  assign hit_ctrl = (addr == CTRL_ADDR);
  assign hit_len  = (addr == LEN_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      stat_q <= 1'b0;
      len_q  <= '0;
    end else begin
      if (take_i) pend_q <= 1'b0;
      if (wr_en && hit_ctrl) begin
        en_q <= wdata[1];
        if (wdata[3] && !busy_i && !pend_q) pend_q <= 1'b1;
      end
      if (wr_en && hit_len) begin
        if (int'(wdata) > DEPTH) len_q <= LW'(DEPTH);
        else                     len_q <= LW'(wdata);
      end
      if (done_i)                   stat_q <= 1'b1;
      else if (rd_en && hit_ctrl)   stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && in_buf) mem[buf_idx] <= wdata;
  end

  always_comb begin
    rdata = 8'h00;
    if (hit_ctrl)     rdata = {4'b0000, pend_q, busy_i, en_q, stat_q};
    else if (hit_len) rdata = 8'(len_q);
    else if (in_buf)  rdata = mem[buf_idx];
  end

  assign rd_byte      = mem[rd_idx];
  assign len_o        = len_q;
  assign start_pend_o = pend_q;
  assign irq_n        = !(stat_q && en_q);

  a_r8_status_sets: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> stat_q);
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && hit_ctrl && !done_i) |=> !stat_q);
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ctrl && busy_i && !pend_q && !take_i) |=> !pend_q);
  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && en_q && !(wr_en && hit_ctrl)) |=> !irq_n);
endmodule

// File: rtl/lapd_tx_ser.sv
module lapd_tx_ser
  import lapd_tx_pkg::*;
#(
  parameter int IW = 7,
  parameter int LW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_i,
  input  logic          start_pend_i,
  input  logic [LW-1:0] len_i,
  input  logic [7:0]    rd_byte_i,
  output logic [IW-1:0] rd_idx_o,
  output logic          take_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          line_o
);
  phase_e        phase_q;
  logic [3:0]    bit_q;
  logic [LW-1:0] byte_q, len_q;
  logic [2:0]    ones_q;
  logic          line_q;
  logic [15:0]   crc;
  logic          stuff, data_bit, fcs_bit, flag_bit, crc_en, last_byte;

  assign stuff     = (ones_q == 3'(STUFF_RUN)) &&
                     (phase_q == PH_DATA || phase_q == PH_FCS || phase_q == PH_CLOSE);
  assign data_bit  = rd_byte_i[bit_q[2:0]];
  assign fcs_bit   = ~crc[bit_q];
  assign flag_bit  = FLAG_BYTE[bit_q[2:0]];
  assign last_byte = (byte_q + LW'(1)) == len_q;
  assign take_o    = slot_i && (phase_q == PH_IDLE) && start_pend_i;
  assign crc_en    = slot_i && (phase_q == PH_DATA) && !stuff;
  assign done_o    = slot_i && (phase_q == PH_CLOSE) && !stuff && (bit_q == 4'd7);
  assign busy_o    = (phase_q != PH_IDLE);
  assign rd_idx_o  = IW'(byte_q);
  assign line_o    = line_q;

  lapd_tx_crc u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (take_o),
    .en_i   (crc_en),
    .bit_i  (data_bit),
    .crc_o  (crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      byte_q  <= '0;
      len_q   <= '0;
      ones_q  <= '0;
      line_q  <= 1'b1;
    end else if (slot_i) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_pend_i) begin
            line_q  <= FLAG_BYTE[0];
            bit_q   <= 4'd1;
            ones_q  <= '0;
            len_q   <= len_i;
            phase_q <= PH_OPEN;
          end else begin
            line_q <= 1'b1;
          end
        end
        PH_OPEN: begin
          line_q <= flag_bit;
          ones_q <= '0;
          if (bit_q == 4'd7) begin
            bit_q   <= '0;
            byte_q  <= '0;
            phase_q <= (len_q == '0) ? PH_FCS : PH_DATA;
          end else begin
            bit_q <= bit_q + 4'd1;
          end
        end
        PH_DATA: begin
          if (stuff) begin
            line_q <= 1'b0;
            ones_q <= '0;
          end else begin
            line_q <= data_bit;
            ones_q <= data_bit ? ones_q + 3'd1 : 3'd0;
            if (bit_q == 4'd7) begin
              bit_q <= '0;
              if (last_byte) phase_q <= PH_FCS;
              else           byte_q  <= byte_q + LW'(1);
            end else begin
              bit_q <= bit_q + 4'd1;
            end
          end
        end
        PH_FCS: begin
          if (stuff) begin
            line_q <= 1'b0;
            ones_q <= '0;
          end else begin
            line_q <= fcs_bit;
            ones_q <= fcs_bit ? ones_q + 3'd1 : 3'd0;
            if (bit_q == 4'd15) begin
              bit_q   <= '0;
              phase_q <= PH_CLOSE;
            end else begin
              bit_q <= bit_q + 4'd1;
            end
          end
        end
        PH_CLOSE: begin
          ones_q <= '0;
          if (stuff) begin
            line_q <= 1'b0;
          end else begin
            line_q <= flag_bit;
            if (bit_q == 4'd7) begin
              bit_q   <= '0;
              phase_q <= PH_IDLE;
            end else begin
              bit_q <= bit_q + 4'd1;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  a_r11_idle_sends_one: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && phase_q == PH_IDLE && !start_pend_i) |=> line_q);
  a_r3_zero_after_five: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_i && stuff) |=> !line_q);
  a_r6_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(take_o));
  a_r6_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));
  a_r2_hold_between_slots: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_i |=> $stable(line_q));
endmodule

// File: rtl/lapd_tx.sv
module lapd_tx #(
  parameter int DEPTH    = 88,
  parameter int BUF_BASE = 'h86,
  parameter int AW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          slot,
  output logic          line_bit,
  output logic          irq_n
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [IW-1:0] rd_idx;
  logic [7:0]    rd_byte;
  logic [LW-1:0] len;
  logic          start_pend, take, busy, done;

  lapd_tx_regs #(
    .DEPTH(DEPTH), .BUF_BASE(BUF_BASE), .AW(AW), .IW(IW), .LW(LW)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .rd_idx       (rd_idx),
    .rd_byte      (rd_byte),
    .len_o        (len),
    .start_pend_o (start_pend),
    .take_i       (take),
    .busy_i       (busy),
    .done_i       (done),
    .irq_n        (irq_n)
  );

  lapd_tx_ser #(.IW(IW), .LW(LW)) u_ser (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_i       (slot),
    .start_pend_i (start_pend),
    .len_i        (len),
    .rd_byte_i    (rd_byte),
    .rd_idx_o     (rd_idx),
    .take_o       (take),
    .busy_o       (busy),
    .done_o       (done),
    .line_o       (line_bit)
  );
endmodule

// File: tb/lapd_tx_tb_top.sv
`timescale 1ns/1ps
module lapd_tx_tb_top;
  localparam int DEPTH = 88;
  localparam int BASE  = 'h86;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, slot = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       line_bit, irq_n;

  int n_chk = 0, n_fail = 0;
  logic [7:0] msg [DEPTH];
  bit exp_q[$];

  always #10 clk = ~clk;

  lapd_tx dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .slot(slot), .line_bit(line_bit), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input bit b);
    logic [15:0] n;
    n = {1'b0, c[15:1]};
    if (c[0] ^ b) n = n ^ 16'h8408;
    return n;
  endfunction

  task automatic push_st(inout int ones, input bit b);
    if (ones == 5) begin exp_q.push_back(1'b0); ones = 0; end
    exp_q.push_back(b);
    ones = b ? ones + 1 : 0;
  endtask

  task automatic build_exp(input int n);
    int ones = 0;
    logic [15:0] c = 16'hFFFF;
    logic [15:0] f;
    exp_q.delete();
    for (int i = 0; i < 8; i++) exp_q.push_back(bit'(8'h7E >> i));
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        push_st(ones, msg[k][i]);
        c = ref_crc(c, msg[k][i]);
      end
    f = ~c;
    for (int i = 0; i < 16; i++) push_st(ones, f[i]);
    if (ones == 5) exp_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) exp_q.push_back(bit'(8'h7E >> i));
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic one_slot(input bit rd_too);
    repeat ($urandom % 3) @(negedge clk);
    @(negedge clk); slot = 1'b1;
    if (rd_too) begin addr = 8'h00; rd_en = 1'b1; end
    @(negedge clk); slot = 1'b0; rd_en = 1'b0;
  endtask

  task automatic load_msg(input int n, input int kind);
    for (int k = 0; k < n; k++) begin
      msg[k] = (kind == 1) ? 8'hFF : 8'($urandom);
      host_wr(8'(BASE + k), msg[k]);
    end
  endtask

  // sends the frame already built in exp_q; ctrl_en is the enable bit to write
  task automatic send_frame(input bit en, input bit rd_last, input bit mid_start);
    logic [7:0] v;
    int bad = 0, first_bad = -1;
    host_wr(8'h00, {4'b0, 1'b1, 1'b0, en, 1'b0});
    peek(8'h00, v);
    check(v[3] == 1'b1 && v[2] == 1'b0, "R6 start pending", v, 8'h08);
    for (int i = 0; i < exp_q.size(); i++) begin
      one_slot(rd_last && (i == exp_q.size() - 1));
      if (line_bit !== exp_q[i]) begin bad++; if (first_bad < 0) first_bad = i; end
      if (i == 0) begin
        peek(8'h00, v);
        check(v[3:2] == 2'b01, "R6 busy after first slot", v[3:2], 1);
      end
      if (i == exp_q.size() - 2) begin
        peek(8'h00, v);
        check(v[2] == 1'b1, "R6 busy before last bit", v[2], 1);
      end
      if (mid_start && i == 20) host_wr(8'h00, {4'b0, 1'b1, 1'b0, en, 1'b0});
    end
    check(bad == 0, "R2 R3 R4 frame bits", first_bad, -1);
    peek(8'h00, v);
    check(v[2] == 1'b0 && v[0] == 1'b1, "R6 R8 busy off status on", v, 8'h01);
    check(irq_n == !en, "R9 irq level", irq_n, !en);
  endtask

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    peek(8'h00, v);
    check(v == 8'h00, "R1 ctrl reset", v, 0);
    check(irq_n == 1'b1 && line_bit == 1'b1, "R1 irq/line reset", {irq_n, line_bit}, 3);

    for (int i = 0; i < 4; i++) begin
      one_slot(0);
      check(line_bit == 1'b1, "R11 idle slot", line_bit, 1);
    end

    // R10 unused bits and buffer readback
    host_wr(8'h00, 8'hF2);
    peek(8'h00, v);
    check(v == 8'h02, "R10 unused bits zero", v, 8'h02);
    host_wr(8'hDD, 8'hA5);
    host_wr(8'h86, 8'h3C);
    peek(8'hDD, v);
    check(v == 8'hA5, "R10 buffer last byte", v, 8'hA5);
    peek(8'h86, v);
    check(v == 8'h3C, "R10 buffer first byte", v, 8'h3C);

    // random message, interrupt enabled, read clears status
    load_msg(10, 0);
    host_wr(8'h01, 8'd10);
    build_exp(10);
    send_frame(1'b1, 1'b0, 1'b0);
    host_rd(8'h00, v);
    peek(8'h00, v);
    check(v[0] == 1'b0 && irq_n == 1'b1, "R8 R9 read clears", {v[0], irq_n}, 1);

    // all ones: heavy stuffing, start written mid frame is ignored
    load_msg(5, 1);
    host_wr(8'h01, 8'd5);
    build_exp(5);
    send_frame(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++) one_slot(0);
    peek(8'h00, v);
    check(v[3:2] == 2'b00 && line_bit == 1'b1, "R7 start ignored while busy", {v[3:2], line_bit}, 1);
    host_rd(8'h00, v);

    // empty message; completion coincides with a status read
    host_wr(8'h01, 8'd0);
    build_exp(0);
    send_frame(1'b1, 1'b1, 1'b0);
    check(exp_q.size() == 32 || exp_q.size() > 32, "R5 empty frame length", exp_q.size(), 32);
    host_rd(8'h00, v);

    // over-range length saturates, full buffer, interrupt disabled
    host_wr(8'h01, 8'd200);
    peek(8'h01, v);
    check(v == 8'(DEPTH), "R5 length saturates", v, DEPTH);
    load_msg(DEPTH, 0);
    build_exp(DEPTH);
    send_frame(1'b0, 1'b0, 1'b0);
    check(irq_n == 1'b1, "R9 irq masked", irq_n, 1);

    // several more random lengths and slot gaps
    for (int r = 0; r < 3; r++) begin
      int n = 1 + ($urandom % 16);
      host_rd(8'h00, v);
      load_msg(n, r == 1 ? 1 : 0);
      host_wr(8'h01, 8'(n));
      build_exp(n);
      send_frame(1'b1, 1'b0, 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule